// File: doc/BRIEF.md
# GPIO Alternate-Function Write Guard

This block protects the alternate-function routing bits of a general-purpose I/O port. A register bus with address, write data and write strobe reaches three guarded registers. A 32-bit key word written to the lock register opens a gate, and any other word closes it. The commit register can only be changed while the gate is open. Each bit of the commit register then allows or blocks writes to the matching bit of the alternate-function register.

Software opens the gate with the key, writes a commit mask, and closes the gate again. After that, only the committed bits of the alternate-function register can still be changed, and the mask itself cannot be changed until the key is written once more. The commit mask and the alternate-function value are brought out as registered outputs, so the pad multiplexer can use them directly.

Top module: `gpio_cfg_guard`

## Requirements
- R1: After synchronous reset the gate is locked, the commit mask is 0xFF and the alternate-function register is 0x00.
- R2: A write of exactly 0x0ACCE551 to offset 0x520 opens the gate. All 32 data bits are compared in the cycle of the strobe. A lock readback then returns 0.
- R3: A write of any other 32-bit value to offset 0x520 closes the gate, including values that differ from the key in one bit only. A lock readback then returns 1.
- R4: A write to the commit register at offset 0x524 while the gate is locked leaves the commit mask unchanged.
- R5: A commit write while the gate is open stores bits 7:0 of the write data. A readback at 0x524 returns those bits with all upper bits 0.
- R6: A write to offset 0x420 replaces alternate-function bit i with data bit i only where commit bit i is 1. All other bits keep their old value.
- R7: Closing the gate after a commit keeps the commit mask, so only the committed bits stay writable.
- R8: The read data is registered. The value for the address presented in one cycle appears after the next clock edge and shows the state before any write on that edge. Unmapped offsets read 0, and writes to them change no state.
- R9: commit_mask_o and altfn_o always equal the commit register and the alternate-function register as read over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Registered read data |
| commit_mask_o | output | 8 | Current commit mask |
| altfn_o | output | 8 | Current alternate-function select |

## Verification
The masked update is swept over all 256 commit masks. Each mask is tried with the data patterns all-zeros, all-ones, 0xA5 and 0x5A. The all-zeros and all-ones patterns show whether committed bits are actually written. The alternating patterns catch bits that are swapped or mixed up between positions. For the key, every one of the 32 single-bit corruptions is written and must re-lock, which shows that the comparison really covers the full word. Commit writes are also made while locked, and writes and reads go to unmapped offsets, to show that the gate holds and that stray accesses have no effect.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MASK_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ALTFN  = 12'h420;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;
endpackage

// File: rtl/guard_key_lock.sv
module guard_key_lock #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h0ACC_E551
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked_o
);
  always_ff @(posedge clk) begin
    if (rst)        locked_o <= 1'b1;
    else if (wr_en) locked_o <= (wdata != KEY);
  end

  // R2: the exact key opens the gate
  a_r2_key_opens: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata == KEY) |=> !locked_o);
  // R3: any other word closes it
  a_r3_other_closes: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata != KEY) |=> locked_o);
  // R8: without a lock write the gate state does not move
  a_r8_lock_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(locked_o));
endmodule

// File: rtl/guard_commit_reg.sv
module guard_commit_reg #(
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              locked,
  input  logic [MASK_W-1:0] wdata,
  output logic [MASK_W-1:0] commit_o
);
  always_ff @(posedge clk) begin
    if (rst)                   commit_o <= '1;
    else if (wr_en && !locked) commit_o <= wdata;
  end

  // R4, R7: a locked gate freezes the commit mask
  a_r4_locked_freeze: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(commit_o));
endmodule

// File: rtl/guard_altfn_reg.sv
module guard_altfn_reg #(
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MASK_W-1:0] mask,
  input  logic [MASK_W-1:0] wdata,
  output logic [MASK_W-1:0] altfn_o
);
  for (genvar b = 0; b < MASK_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                  altfn_o[b] <= 1'b0;
      else if (wr_en && mask[b]) altfn_o[b] <= wdata[b];
    end
  end

  // R6: bits with a zero commit bit never change
  a_r6_masked_only: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((altfn_o ^ $past(altfn_o)) & ~$past(mask)) == '0);
endmodule

// File: rtl/gpio_cfg_guard.sv
module gpio_cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [MASK_W-1:0] commit_mask_o,
  output logic [MASK_W-1:0] altfn_o
);
  logic hit_lock, hit_commit, hit_altfn;
  logic locked;

  assign hit_lock   = (bus_addr == OFS_LOCK);
  assign hit_commit = (bus_addr == OFS_COMMIT);
  assign hit_altfn  = (bus_addr == OFS_ALTFN);

  guard_key_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst(rst), .wr_en(bus_wr && hit_lock),
    .wdata(bus_wdata), .locked_o(locked)
  );

  guard_commit_reg #(.MASK_W(MASK_W)) u_commit (
    .clk(clk), .rst(rst), .wr_en(bus_wr && hit_commit), .locked(locked),
    .wdata(bus_wdata[MASK_W-1:0]), .commit_o(commit_mask_o)
  );

  guard_altfn_reg #(.MASK_W(MASK_W)) u_altfn (
    .clk(clk), .rst(rst), .wr_en(bus_wr && hit_altfn), .mask(commit_mask_o),
    .wdata(bus_wdata[MASK_W-1:0]), .altfn_o(altfn_o)
  );

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (hit_lock)        rd_next = DATA_W'(locked);
    else if (hit_commit) rd_next = DATA_W'(commit_mask_o);
    else if (hit_altfn)  rd_next = DATA_W'(altfn_o);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (locked && commit_mask_o == '1 && altfn_o == '0));
  // R8: unmapped writes leave all state alone
  a_r8_stray_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit_lock && !hit_commit && !hit_altfn) |=>
      ($stable(locked) && $stable(commit_mask_o) && $stable(altfn_o)));
  // R5: readback never carries bits above the mask width
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:MASK_W] == '0);
endmodule

// File: tb/gpio_cfg_guard_tb.sv
module gpio_cfg_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic [31:0] bus_rdata;
  logic [7:0]  commit_mask_o, altfn_o;

  int checks = 0, fails = 0;
  bit m_locked;
  logic [7:0] m_commit, m_alt;

  localparam logic [31:0] K = 32'h0ACC_E551;

  always #5 clk = ~clk;

  gpio_cfg_guard dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .commit_mask_o(commit_mask_o), .altfn_o(altfn_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic outs(string req);
    check(req, {24'd0, commit_mask_o}, {24'd0, m_commit});
    check(req, {24'd0, altfn_o}, {24'd0, m_alt});
  endtask

  initial begin : watchdog
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_locked = 1; m_commit = 8'hFF; m_alt = 8'h00;

    // R1 reset state
    outs("R1");
    rd(12'h520, r); check("R1 lock", r, 32'd1);

    // R8 unmapped read / write
    rd(12'h100, r); check("R8 unmapped read", r, 32'd0);
    wr(12'h428, 32'hFFFF_FFFF); outs("R8 stray write");

    // R4 commit write while locked ignored
    wr(12'h524, 32'h0000_0012); outs("R4");
    rd(12'h524, r); check("R4 readback", r, 32'h0000_00FF);

    // R3 every single-bit corruption of the key re-locks
    for (int b = 0; b < 32; b++) begin
      wr(12'h520, K); rd(12'h520, r); check("R2 unlock", r, 32'd0);
      wr(12'h520, K ^ (32'd1 << b)); rd(12'h520, r); check("R3 relock", r, 32'd1);
    end

    // R5/R6 exhaustive commit masks x data patterns
    for (int m = 0; m < 256; m++) begin
      wr(12'h520, K);
      wr(12'h524, {24'hABCDEF, 8'(m)}); m_commit = 8'(m);
      rd(12'h524, r); check("R5 commit readback", r, {24'd0, 8'(m)});
      wr(12'h520, 32'h0);   // relock, R7
      for (int p = 0; p < 4; p++) begin
        logic [7:0] d;
        d = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'h5A;
        wr(12'h420, {24'h5A5A5A, d});
        m_alt = (m_alt & ~m_commit) | (d & m_commit);
        check("R6 altfn", {24'd0, altfn_o}, {24'd0, m_alt});
      end
      rd(12'h420, r); check("R9 altfn readback", r, {24'd0, m_alt});
      check("R9 commit out", {24'd0, commit_mask_o}, {24'd0, m_commit});
    end

    // R7 relocked: commit keeps value, further commit writes ignored
    wr(12'h524, 32'h0000_0000); outs("R7");

    // R8 read shows state before same-edge write
    @(negedge clk);
    bus_addr = 12'h420; bus_wdata = {24'd0, ~m_alt}; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R8 read before write", bus_rdata, {24'd0, m_alt});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule